// File: doc/BRIEF.md
# PoE Port Overload and Disconnect Supervisor

This block watches the current drawn by each powered Ethernet port and decides when a port's power switch must be turned off. It works on 16-bit current samples, with one least significant bit (LSB) worth 100 µA. Each sample comes with a valid strobe. Each port has its own current-limit select, its own PoE/PoE+ mode bit and its own thermal flag. One package over-temperature flag is shared by all ports.

A port is switched on by a rising edge on its enable input. It then runs until one of several checks fires, each tracked by its own timer or comparator:
- a hard short-circuit cutoff, which also gives a fixed-length gate clamp pulse;
- a sustained-overload timeout;
- a maintain-power undercurrent timeout;
- a thermal trip in PoE+ mode;
- a package over-temperature shutdown.

The cause is latched as a fault code until the host clears it. After a clear the port remains off until its enable rises again. The slow timers count ticks from a shared prescaler, so their lengths (60 ms and 350 ms at 1 µs ticks) are plain counter limits. While the package is too hot, the block also raises a line that tells the detection logic to stand down.

Top module: `poe_port_guard`

## Requirements
- R1: After reset every gate-off output is high, every clamp output is low, every fault code is 0 and the detection-block output is low.
- R2: A port turns on when its enable is high in a cycle where it was low in the previous cycle, provided the port holds no fault and the package flag is low. Its gate-off output goes low one cycle after that edge.
- R3: A valid sample at or above the short-circuit threshold turns an active port off in the next cycle with fault code 2. The threshold is 5000 LSB when the limit select is 0 and 10000 LSB when it is 1. A sample one LSB below the threshold has no effect.
- R4: A short-circuit trip raises the port's clamp output in the same cycle that gate-off rises. The clamp stays high for exactly CLAMP_CYC cycles.
- R5: While every valid sample is at or above the operating limit, the port turns off with fault code 1 within ICUT_TICKS ticks, and not before ICUT_TICKS-1 ticks. The limit is 4000 LSB for select 0 and 8000 LSB for select 1. A valid sample below the limit restarts this timer.
- R6: The limit select changes the overload decision: a steady 4500 LSB is an overload with select 0 and is ignored with select 1.
- R7: While every valid sample is below 75 LSB, the port turns off with fault code 3 after more than DISC_TICKS ticks (at most DISC_TICKS+1). A valid sample of 75 LSB or more restarts this timer.
- R8: With the mode bit at 1 (PoE+), a port thermal flag turns an active port off in the next cycle with fault code 1. With the mode bit at 0 the flag has no effect.
- R9: A high package flag turns every active port off in the next cycle with fault code 4 and keeps every port from turning on. The detection-block output follows the package flag one cycle later.
- R10: A fault code holds until a clear pulse for that port. After the clear the code is 0 and the port stays off until its enable rises again.
- R11: Dropping enable turns an active port off in the next cycle with fault code 0.
- R12: A trip on one port leaves the gate and fault code of every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en_i | input | NPORTS | Per-port enable; a rising edge turns the port on |
| flt_clr_i | input | NPORTS | Per-port fault clear pulse |
| cur_smp_i | input | NPORTS*16 | Current samples, 100 µA per LSB, port p at bits [16p+15:16p] |
| cur_vld_i | input | NPORTS | Sample valid strobe per port |
| lim_sel_i | input | NPORTS | Limit select: 0 gives 400 mA, 1 gives 800 mA |
| plus_mode_i | input | NPORTS | 1 for PoE+ mode, 0 for PoE mode |
| port_hot_i | input | NPORTS | Per-port thermal flag |
| pkg_hot_i | input | 1 | Package over-temperature flag |
| gate_off_o | output | NPORTS | High while the port's power switch must be off |
| clamp_o | output | NPORTS | Gate clamp pulse after a short circuit |
| flt_code_o | output | NPORTS*3 | Latched fault code per port: 0 none, 1 overload, 2 short, 3 disconnect, 4 package heat |
| det_blk_o | output | 1 | High while detection must be held off |

## Verification
The assertions assume that the fault clear, enable and thermal inputs are synchronous to the clock and free of unknown values after reset. The clamp-length property also assumes that a port is not re-enabled and shorted again while its clamp is still running. The stimulus changes every input only on the falling edge. It holds a short-circuited port in the cleared state well beyond CLAMP_CYC cycles before the next enable. It keeps the package flag low except in the one sequence that tests it.

// File: rtl/poe_guard_pkg.sv
package poe_guard_pkg;

    localparam int SMP_W = 16;
    localparam int FLT_W = 3;

    localparam logic [SMP_W-1:0] LIM_LO = 16'd4000;
    localparam logic [SMP_W-1:0] LIM_HI = 16'd8000;
    localparam logic [SMP_W-1:0] SC_LO  = 16'd5000;
    localparam logic [SMP_W-1:0] SC_HI  = 16'd10000;
    localparam logic [SMP_W-1:0] UC_THR = 16'd75;

    typedef enum logic [FLT_W-1:0] {
        FLT_NONE  = 3'd0,
        FLT_ICUT  = 3'd1,
        FLT_SHORT = 3'd2,
        FLT_DISC  = 3'd3,
        FLT_HOT   = 3'd4
    } flt_code_e;

    typedef enum logic [1:0] {
        PS_OFF,
        PS_ON,
        PS_TRIP
    } port_st_e;

    typedef struct packed {
        logic short_hit;
        logic over_lim;
        logic under_min;
    } smp_class_t;

    function automatic smp_class_t classify_smp(input logic [SMP_W-1:0] s, input logic hi);
        smp_class_t c;
        c.short_hit = (s >= (hi ? SC_HI : SC_LO));
        c.over_lim  = (s >= (hi ? LIM_HI : LIM_LO));
        c.under_min = (s < UC_THR);
        return c;
    endfunction

endpackage

// File: rtl/poe_tick_gen.sv
module poe_tick_gen #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q == CNT_W'(DIV - 1)) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R5

endmodule

// File: rtl/poe_tick_timer.sv
module poe_tick_timer #(
    parameter int TERM = 60000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int W = $clog2(TERM + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != W'(TERM))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == W'(TERM));

    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run_i && !tick_i) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/poe_port_ctl.sv
module poe_port_ctl
    import poe_guard_pkg::*;
#(
    parameter int ICUT_TICKS = 60000,
    parameter int DISC_TICKS = 350000,
    parameter int CLAMP_CYC  = 1250
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [SMP_W-1:0] smp_i,
    input  logic             vld_i,
    input  logic             lim_sel_i,
    input  logic             plus_i,
    input  logic             therm_i,
    input  logic             hot_i,
    output logic             gate_off_o,
    output logic             clamp_o,
    output logic [FLT_W-1:0] code_o
);
    localparam int CL_W = $clog2(CLAMP_CYC + 1);

    smp_class_t cls;
    port_st_e   st_q, st_d;
    flt_code_e  code_q, code_d;
    logic       en_q, en_rise;
    logic       ovl_q, uc_q;
    logic       icut_exp, disc_exp;
    logic       clamp_load;
    logic [CL_W-1:0] clamp_cnt_q;

    assign cls     = classify_smp(smp_i, lim_sel_i);
    assign en_rise = en_i && !en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_i;
    end

    // Level flags that persist between samples
    always_ff @(posedge clk) begin
        if (rst || st_q != PS_ON) begin
            ovl_q <= 1'b0;
            uc_q  <= 1'b0;
        end else if (vld_i) begin
            ovl_q <= cls.over_lim;
            uc_q  <= cls.under_min;
        end
    end

    poe_tick_timer #(.TERM(ICUT_TICKS)) u_icut_tmr (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .run_i    (ovl_q),
        .expired_o(icut_exp)
    );

    poe_tick_timer #(.TERM(DISC_TICKS + 1)) u_disc_tmr (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .run_i    (uc_q),
        .expired_o(disc_exp)
    );

    always_comb begin
        st_d       = st_q;
        code_d     = code_q;
        clamp_load = 1'b0;
        case (st_q)
            PS_OFF: begin
                code_d = FLT_NONE;
                if (en_rise && !hot_i) st_d = PS_ON;
            end
            PS_ON: begin
                if (hot_i) begin
                    st_d   = PS_TRIP;
                    code_d = FLT_HOT;
                end else if (vld_i && cls.short_hit) begin
                    st_d       = PS_TRIP;
                    code_d     = FLT_SHORT;
                    clamp_load = 1'b1;
                end else if ((therm_i && plus_i) || icut_exp) begin
                    st_d   = PS_TRIP;
                    code_d = FLT_ICUT;
                end else if (disc_exp) begin
                    st_d   = PS_TRIP;
                    code_d = FLT_DISC;
                end else if (!en_i) begin
                    st_d = PS_OFF;
                end
            end
            PS_TRIP: begin
                if (clr_i) begin
                    st_d   = PS_OFF;
                    code_d = FLT_NONE;
                end
            end
            default: begin
                st_d   = PS_OFF;
                code_d = FLT_NONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PS_OFF;
            code_q <= FLT_NONE;
        end else begin
            st_q   <= st_d;
            code_q <= code_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    clamp_cnt_q <= '0;
        else if (clamp_load)        clamp_cnt_q <= CL_W'(CLAMP_CYC);
        else if (clamp_cnt_q != '0) clamp_cnt_q <= clamp_cnt_q - 1'b1;
    end

    assign gate_off_o = (st_q != PS_ON);
    assign clamp_o    = (clamp_cnt_q != '0);
    assign code_o     = code_q;

    // Checker: length of each clamp pulse
    logic [CL_W-1:0] run_len_q;
    always_ff @(posedge clk) begin
        if (rst || !clamp_o)                   run_len_q <= '0;
        else if (run_len_q < CL_W'(CLAMP_CYC)) run_len_q <= run_len_q + 1'b1;
    end

    AST_CLAMP_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(clamp_o) |-> (run_len_q == CL_W'(CLAMP_CYC))); // R4
    AST_CLAMP_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
        clamp_o |-> gate_off_o); // R4
    AST_SHORT_TRIP: assert property (@(posedge clk) disable iff (rst)
        (!gate_off_o && vld_i && cls.short_hit && !hot_i) |=> (gate_off_o && code_o == FLT_SHORT)); // R3
    AST_THERM_PLUS: assert property (@(posedge clk) disable iff (rst)
        (!gate_off_o && therm_i && plus_i && !hot_i) |=> gate_off_o); // R8
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (code_o != FLT_NONE && !clr_i) |=> $stable(code_o)); // R10
    AST_CODE_OFF: assert property (@(posedge clk) disable iff (rst)
        (code_o != FLT_NONE) |-> gate_off_o); // R10

endmodule

// File: rtl/poe_port_guard.sv
module poe_port_guard
    import poe_guard_pkg::*;
#(
    parameter int NPORTS     = 4,
    parameter int TICK_DIV   = 125,
    parameter int ICUT_TICKS = 60000,
    parameter int DISC_TICKS = 350000,
    parameter int CLAMP_CYC  = 1250
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPORTS-1:0]       port_en_i,
    input  logic [NPORTS-1:0]       flt_clr_i,
    input  logic [NPORTS*SMP_W-1:0] cur_smp_i,
    input  logic [NPORTS-1:0]       cur_vld_i,
    input  logic [NPORTS-1:0]       lim_sel_i,
    input  logic [NPORTS-1:0]       plus_mode_i,
    input  logic [NPORTS-1:0]       port_hot_i,
    input  logic                    pkg_hot_i,
    output logic [NPORTS-1:0]       gate_off_o,
    output logic [NPORTS-1:0]       clamp_o,
    output logic [NPORTS*FLT_W-1:0] flt_code_o,
    output logic                    det_blk_o
);
    logic tick;

    poe_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .tick_o(tick)
    );

    always_ff @(posedge clk) begin
        if (rst) det_blk_o <= 1'b0;
        else     det_blk_o <= pkg_hot_i;
    end

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        poe_port_ctl #(
            .ICUT_TICKS(ICUT_TICKS),
            .DISC_TICKS(DISC_TICKS),
            .CLAMP_CYC (CLAMP_CYC)
        ) u_port (
            .clk       (clk),
            .rst       (rst),
            .tick_i    (tick),
            .en_i      (port_en_i[g]),
            .clr_i     (flt_clr_i[g]),
            .smp_i     (cur_smp_i[g*SMP_W +: SMP_W]),
            .vld_i     (cur_vld_i[g]),
            .lim_sel_i (lim_sel_i[g]),
            .plus_i    (plus_mode_i[g]),
            .therm_i   (port_hot_i[g]),
            .hot_i     (pkg_hot_i),
            .gate_off_o(gate_off_o[g]),
            .clamp_o   (clamp_o[g]),
            .code_o    (flt_code_o[g*FLT_W +: FLT_W])
        );
    end

    AST_HOT_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        pkg_hot_i |=> (&gate_off_o)); // R9
    AST_DET_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        pkg_hot_i |=> det_blk_o); // R9
    AST_DET_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !pkg_hot_i |=> !det_blk_o); // R9

endmodule

// File: tb/test_poe_port_guard.sv
module test_poe_port_guard;
    localparam int NP  = 4;
    localparam int DIV = 4;
    localparam int IT  = 20;
    localparam int DT  = 30;
    localparam int CC  = 10;

    // {lim_sel, sample, expected code after one sample}
    localparam bit [19:0] VECS [0:7] = '{
        {1'b0, 16'd4999,  3'd0},
        {1'b0, 16'd5000,  3'd2},
        {1'b1, 16'd5000,  3'd0},
        {1'b1, 16'd9999,  3'd0},
        {1'b1, 16'd10000, 3'd2},
        {1'b0, 16'd65535, 3'd2},
        {1'b0, 16'd100,   3'd0},
        {1'b1, 16'd0,     3'd0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NP-1:0]    en = '0, clr = '0, vld = '0, lsel = '0, plus = '0, therm = '0;
    logic [NP*16-1:0] smp = '0;
    logic             phot = 1'b0;
    logic [NP-1:0]    goff, clamp;
    logic [NP*3-1:0]  code;
    logic             detb;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    poe_port_guard #(
        .NPORTS(NP), .TICK_DIV(DIV), .ICUT_TICKS(IT), .DISC_TICKS(DT), .CLAMP_CYC(CC)
    ) i_poe_port_guard (
        .clk(clk), .rst(rst), .port_en_i(en), .flt_clr_i(clr), .cur_smp_i(smp),
        .cur_vld_i(vld), .lim_sel_i(lsel), .plus_mode_i(plus), .port_hot_i(therm),
        .pkg_hot_i(phot), .gate_off_o(goff), .clamp_o(clamp), .flt_code_o(code),
        .det_blk_o(detb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int cd(input int p);
        return int'(code[p*3 +: 3]);
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic port_up(input int p);
        en[p] = 1'b0; cyc(1);
        en[p] = 1'b1; cyc(1);
    endtask

    task automatic port_down(input int p);
        vld[p] = 1'b0; therm[p] = 1'b0;
        en[p] = 1'b0; clr[p] = 1'b1; cyc(1);
        clr[p] = 1'b0; cyc(1);
    endtask

    task automatic apply(input int p, input logic [15:0] v);
        smp[p*16 +: 16] = v; vld[p] = 1'b1; cyc(1);
        vld[p] = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(2);
        // R1 reset state
        chk(goff == '1, "R1 gate_off", int'(goff), 15);
        chk(clamp == '0, "R1 clamp", int'(clamp), 0);
        chk(code == '0, "R1 codes", int'(code), 0);
        chk(detb == 1'b0, "R1 det_blk", int'(detb), 0);

        // R2 turn-on
        port_up(0);
        chk(goff[0] == 1'b0, "R2 on after enable edge", int'(goff[0]), 0);
        port_down(0);

        // R3 / R6 table of single-sample threshold vectors
        for (int i = 0; i < 8; i++) begin
            lsel[0] = VECS[i][19];
            port_up(0);
            apply(0, VECS[i][18:3]);
            chk(cd(0) == int'(VECS[i][2:0]), "R3 short threshold code", cd(0), int'(VECS[i][2:0]));
            chk(goff[0] == (VECS[i][2:0] != 3'd0), "R3 short threshold gate", int'(goff[0]),
                int'(VECS[i][2:0] != 3'd0));
            port_down(0);
            cyc(CC + 2);
        end
        lsel[0] = 1'b0;

        // R4 clamp length
        begin
            int hi_cnt = 0;
            port_up(0);
            apply(0, 16'd7000);
            chk(clamp[0] && goff[0], "R4 clamp with gate-off", int'(clamp[0]), 1);
            for (int k = 0; k < 30; k++) begin
                if (clamp[0]) hi_cnt++;
                cyc(1);
            end
            chk(hi_cnt == CC, "R4 clamp length", hi_cnt, CC);
            port_down(0);
        end

        // R5 overload timeout
        port_up(0);
        smp[15:0] = 16'd4500; vld[0] = 1'b1;
        cyc((IT - 1) * DIV + 1);
        chk(goff[0] == 1'b0, "R5 not tripped early", int'(goff[0]), 0);
        cyc(DIV + 1);
        chk(goff[0] && cd(0) == 1, "R5 overload trip code", cd(0), 1);
        port_down(0);

        // R5 restart by below-limit sample
        port_up(0);
        smp[15:0] = 16'd4500; vld[0] = 1'b1;
        cyc(70);
        smp[15:0] = 16'd1000; cyc(1);
        smp[15:0] = 16'd4500;
        cyc((IT - 1) * DIV + 1);
        chk(goff[0] == 1'b0, "R5 timer restarted", int'(goff[0]), 0);
        cyc(DIV + 1);
        chk(cd(0) == 1, "R5 trips after restart", cd(0), 1);
        port_down(0);

        // R6 limit select
        lsel[0] = 1'b1;
        port_up(0);
        smp[15:0] = 16'd4500; vld[0] = 1'b1;
        cyc(IT * DIV + 10);
        chk(goff[0] == 1'b0 && cd(0) == 0, "R6 4500 ignored at high limit", cd(0), 0);
        smp[15:0] = 16'd9000;
        cyc(IT * DIV + 4);
        chk(cd(0) == 1, "R6 9000 overloads at high limit", cd(0), 1);
        port_down(0);
        lsel[0] = 1'b0;

        // R7 undercurrent disconnect
        port_up(0);
        smp[15:0] = 16'd50; vld[0] = 1'b1;
        cyc(DT * DIV + 1);
        chk(goff[0] == 1'b0, "R7 not disconnected early", int'(goff[0]), 0);
        cyc(DIV + 1);
        chk(goff[0] && cd(0) == 3, "R7 disconnect code", cd(0), 3);
        port_down(0);

        port_up(0);
        smp[15:0] = 16'd50; vld[0] = 1'b1;
        cyc(110);
        smp[15:0] = 16'd75; cyc(1);
        smp[15:0] = 16'd50;
        cyc(DT * DIV + 1);
        chk(goff[0] == 1'b0, "R7 timer restarted", int'(goff[0]), 0);
        port_down(0);

        // R8 thermal flag
        plus[0] = 1'b1;
        port_up(0);
        therm[0] = 1'b1; cyc(1);
        chk(goff[0] && cd(0) == 1, "R8 PoE+ thermal trip", cd(0), 1);
        port_down(0);
        plus[0] = 1'b0;
        port_up(0);
        therm[0] = 1'b1; cyc(20);
        chk(goff[0] == 1'b0 && cd(0) == 0, "R8 PoE thermal ignored", int'(goff[0]), 0);
        port_down(0);

        // R9 package over-temperature
        port_up(0);
        port_up(1);
        phot = 1'b1; cyc(1);
        chk(goff == '1, "R9 all gates off", int'(goff), 15);
        chk(detb == 1'b1, "R9 det_blk high", int'(detb), 1);
        chk(cd(0) == 4 && cd(1) == 4, "R9 heat code", cd(0), 4);
        chk(cd(2) == 0, "R9 idle port no code", cd(2), 0);
        en[2] = 1'b1; cyc(2);
        chk(goff[2] == 1'b1, "R9 no turn-on while hot", int'(goff[2]), 1);
        phot = 1'b0; cyc(1);
        chk(detb == 1'b0, "R9 det_blk released", int'(detb), 0);
        port_down(0); port_down(1); port_down(2);

        // R10 latch and re-enable
        port_up(0);
        apply(0, 16'd6000);
        cyc(30);
        chk(cd(0) == 2 && goff[0], "R10 code held", cd(0), 2);
        clr[0] = 1'b1; cyc(1); clr[0] = 1'b0;
        chk(cd(0) == 0, "R10 code cleared", cd(0), 0);
        cyc(3);
        chk(goff[0] == 1'b1, "R10 stays off after clear", int'(goff[0]), 1);
        en[0] = 1'b0; cyc(1); en[0] = 1'b1; cyc(1);
        chk(goff[0] == 1'b0, "R10 on after re-enable", int'(goff[0]), 0);

        // R11 enable drop
        en[0] = 1'b0; cyc(1);
        chk(goff[0] == 1'b1 && cd(0) == 0, "R11 off with no code", cd(0), 0);
        port_down(0);
        cyc(CC);

        // R12 port independence
        port_up(0);
        port_up(1);
        apply(1, 16'd8000);
        chk(cd(1) == 2, "R12 port1 short", cd(1), 2);
        chk(goff[0] == 1'b0 && cd(0) == 0, "R12 port0 untouched", cd(0), 0);
        port_down(0); port_down(1);

        done = 1'b1;
        finish_run();
    end
endmodule